// File: doc/BRIEF.md
# Endian-aware write data unpacker

This block takes one 64-bit write word, together with its eight byte enables, from an on-chip interconnect. It breaks the word into a series of beats for an external memory data lane. The lane is either 16 or 32 bits wide. Each beat carries the matching byte enables, and the beats are issued in ascending memory address order. A big-endian qualifier arrives with each request. For a little-endian word, the least significant slice goes to the lowest address. For a big-endian word, the least significant slice goes to the highest address.

Each of two chip selects has its own 3-bit configuration code. The code sets the lane width and, for a 16-bit lane, which half of the 32-bit beat bus carries the data. The code is read from the chip select given with the request, at the moment the word is accepted. A reserved code falls back to the two-beat 32-bit little-endian mapping and flags an error on every beat of that word.

The input uses a valid/ready handshake. The output presents a beat with a valid strobe, accepts it with a ready signal, and marks the final beat of each word with a last flag. A new word is accepted only once the previous word has been fully drained.

Top module: `wdata_beat_splitter`

## Requirements
- R1: While reset is asserted and until the first word is accepted, the block holds `in_ready_o`=1, `beat_valid_o`=0, `beat_last_o`=0 and `cfg_err_o`=0.
- R2: A word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1. The first beat is valid in the next cycle. `in_ready_o` stays 0 from then on, and returns to 1 in the cycle after the last beat is taken (`beat_valid_o` and `beat_ready_i` both 1).
- R3: Code 3'b000 or 3'b001 gives four beats per word, and code 3'b010 gives two. `beat_last_o` is 1 only on the final beat.
- R4: For a little-endian word (`in_big_endian_i`=0), beat k carries input bits [k*W +: W], where W is the lane width.
- R5: For a big-endian word (`in_big_endian_i`=1), beat k carries input bits [(N-1-k)*W +: W], where N is the number of beats.
- R6: Code 3'b000 places the 16-bit slice on `beat_data_o[15:0]` and code 3'b001 places it on `beat_data_o[31:16]`. In both cases the other half and its byte enables are 0.
- R7: Each beat's byte enables are the input enables of the same bytes, at the same positions as the data.
- R8: While `beat_valid_o`=1 and `beat_ready_i`=0, the beat data, enables, last flag and error flag hold their values.
- R9: `in_cs_i`=0 selects `cfg_i[2:0]` and `in_cs_i`=1 selects `cfg_i[5:3]`. The code is sampled at acceptance, so a later change in `cfg_i` does not affect a word already taken.
- R10: Codes 3'b011 to 3'b111 give two 32-bit little-endian beats, whatever the endianness qualifier, with `cfg_err_o`=1 on each of those beats.
- R11: While a word is being issued, `in_ready_o` stays 0, and a pending request neither alters the beats in flight nor is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Write word offered |
| in_ready_o | output | 1 | Block can accept a word |
| in_data_i | input | 64 | Write data word |
| in_be_i | input | 8 | Byte enables of the word |
| in_big_endian_i | input | 1 | Endianness qualifier of the request, 1 = big |
| in_cs_i | input | 1 | Chip select of the request |
| cfg_i | input | 6 | Configuration codes: [2:0] chip select 0, [5:3] chip select 1 |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Downstream takes the beat |
| beat_data_o | output | 32 | Beat data, lane-steered |
| beat_be_o | output | 4 | Beat byte enables |
| beat_last_o | output | 1 | Final beat of the word |
| cfg_err_o | output | 1 | Current word uses a reserved code |

## Verification
The first beat is due one cycle after the accepting edge. Each later beat is due one cycle after the edge that took the previous one. `in_ready_o` rises one cycle after the last beat is taken. A stalled beat holds its value until the edge where ready is seen.

The bench keeps a queue of expected beats. It fills the queue on the accepting edge and pops it on each taking edge. It compares the queue head with the outputs one nanosecond before every rising edge, so each comparison falls in the cycle the result is due and after all inputs have settled. The order of expected slices is computed from R4, R5, R6 and R10, independently of the hardware.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int CFG_W = 3;

  typedef enum logic [CFG_W-1:0] {
    CFG_N16_LO = 3'd0,
    CFG_N16_HI = 3'd1,
    CFG_W32    = 3'd2
  } cfg_code_e;

  typedef struct packed {
    logic wide;
    logic hi_lane;
    logic big;
    logic err;
  } beat_mode_t;
endpackage

// File: rtl/wbs_cfg_dec.sv
module wbs_cfg_dec
  import wbs_pkg::*;
(
  input  logic [CFG_W-1:0] code_i,
  output logic             wide_o,
  output logic             hi_lane_o,
  output logic             force_le_o,
  output logic             err_o
);
  always_comb begin
    wide_o     = 1'b1;
    hi_lane_o  = 1'b0;
    force_le_o = 1'b0;
    err_o      = 1'b0;
    case (code_i)
      CFG_N16_LO: wide_o = 1'b0;
      CFG_N16_HI: begin
        wide_o    = 1'b0;
        hi_lane_o = 1'b1;
      end
      CFG_W32: wide_o = 1'b1;
      default: begin
        // reserved: fall back to 32-bit little-endian
        force_le_o = 1'b1;
        err_o      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/wbs_ctrl.sv
module wbs_ctrl #(
  parameter int N_NARROW = 4,
  parameter int N_WIDE   = 2,
  localparam int IDX_W   = $clog2(N_NARROW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             take_i,
  input  logic             wide_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             last_o
);
  logic [IDX_W-1:0] final_idx;

  assign final_idx = wide_i ? IDX_W'(N_WIDE - 1) : IDX_W'(N_NARROW - 1);
  assign last_o    = busy_o && (beat_o == final_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      beat_o <= '0;
    end else if (accept_i) begin
      busy_o <= 1'b1;
      beat_o <= '0;
    end else if (take_i) begin
      if (last_o) begin
        busy_o <= 1'b0;
        beat_o <= '0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbs_slice.sv
module wbs_slice #(
  parameter int IN_W     = 64,
  parameter int LANE_W   = 32,
  parameter int NARROW_W = 16,
  localparam int IN_B     = IN_W / 8,
  localparam int LANE_B   = LANE_W / 8,
  localparam int NARROW_B = NARROW_W / 8,
  localparam int N_NARROW = IN_W / NARROW_W,
  localparam int N_WIDE   = IN_W / LANE_W,
  localparam int RATIO    = LANE_W / NARROW_W,
  localparam int IDX_W    = $clog2(N_NARROW)
) (
  input  logic [IN_W-1:0]   data_i,
  input  logic [IN_B-1:0]   be_i,
  input  logic [IDX_W-1:0]  beat_i,
  input  logic              wide_i,
  input  logic              big_i,
  input  logic              hi_lane_i,
  output logic [LANE_W-1:0] data_o,
  output logic [LANE_B-1:0] be_o
);
  logic [IDX_W-1:0]  n_last, pos, unit;
  logic [LANE_W-1:0] shd, nar_d;
  logic [LANE_B-1:0] shb, nar_b;

  always_comb begin
    n_last = wide_i ? IDX_W'(N_WIDE - 1) : IDX_W'(N_NARROW - 1);
    // big-endian walks slices from the top down
    pos    = big_i ? n_last - beat_i : beat_i;
    unit   = wide_i ? IDX_W'(pos * RATIO) : pos;
    shd    = LANE_W'(data_i >> (unit * NARROW_W));
    shb    = LANE_B'(be_i >> (unit * NARROW_B));
    nar_d  = LANE_W'(shd[NARROW_W-1:0]);
    nar_b  = LANE_B'(shb[NARROW_B-1:0]);
    if (wide_i) begin
      data_o = shd;
      be_o   = shb;
    end else if (hi_lane_i) begin
      data_o = nar_d << (LANE_W - NARROW_W);
      be_o   = nar_b << (LANE_B - NARROW_B);
    end else begin
      data_o = nar_d;
      be_o   = nar_b;
    end
  end
endmodule

// File: rtl/wdata_beat_splitter.sv
module wdata_beat_splitter
  import wbs_pkg::*;
#(
  parameter int IN_W     = 64,
  parameter int LANE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int NUM_CS   = 2,
  localparam int IN_B     = IN_W / 8,
  localparam int LANE_B   = LANE_W / 8,
  localparam int N_NARROW = IN_W / NARROW_W,
  localparam int N_WIDE   = IN_W / LANE_W,
  localparam int IDX_W    = $clog2(N_NARROW),
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [IN_W-1:0]         in_data_i,
  input  logic [IN_B-1:0]         in_be_i,
  input  logic                    in_big_endian_i,
  input  logic [CS_W-1:0]         in_cs_i,
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  output logic                    beat_valid_o,
  input  logic                    beat_ready_i,
  output logic [LANE_W-1:0]       beat_data_o,
  output logic [LANE_B-1:0]       beat_be_o,
  output logic                    beat_last_o,
  output logic                    cfg_err_o
);
  logic [NUM_CS-1:0] dec_wide, dec_hi, dec_fle, dec_err;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
    wbs_cfg_dec u_dec (
      .code_i     (cfg_i[g*CFG_W +: CFG_W]),
      .wide_o     (dec_wide[g]),
      .hi_lane_o  (dec_hi[g]),
      .force_le_o (dec_fle[g]),
      .err_o      (dec_err[g])
    );
  end

  beat_mode_t       mode_d, mode_q;
  logic [IN_W-1:0]  data_q;
  logic [IN_B-1:0]  be_q;
  logic             busy, accept, take, last;
  logic [IDX_W-1:0] beat_idx;
  logic [LANE_W-1:0] sl_data;
  logic [LANE_B-1:0] sl_be;

  assign in_ready_o = ~busy;
  assign accept     = in_valid_i & in_ready_o;
  assign take       = busy & beat_ready_i;

  always_comb begin
    mode_d.wide    = dec_wide[in_cs_i];
    mode_d.hi_lane = dec_hi[in_cs_i];
    mode_d.big     = in_big_endian_i & ~dec_fle[in_cs_i];
    mode_d.err     = dec_err[in_cs_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      be_q   <= '0;
      mode_q <= '0;
    end else if (accept) begin
      data_q <= in_data_i;
      be_q   <= in_be_i;
      mode_q <= mode_d;
    end
  end

  wbs_ctrl #(
    .N_NARROW (N_NARROW),
    .N_WIDE   (N_WIDE)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .take_i   (take),
    .wide_i   (mode_q.wide),
    .busy_o   (busy),
    .beat_o   (beat_idx),
    .last_o   (last)
  );

  wbs_slice #(
    .IN_W     (IN_W),
    .LANE_W   (LANE_W),
    .NARROW_W (NARROW_W)
  ) u_slice (
    .data_i    (data_q),
    .be_i      (be_q),
    .beat_i    (beat_idx),
    .wide_i    (mode_q.wide),
    .big_i     (mode_q.big),
    .hi_lane_i (mode_q.hi_lane),
    .data_o    (sl_data),
    .be_o      (sl_be)
  );

  assign beat_valid_o = busy;
  assign beat_data_o  = busy ? sl_data : '0;
  assign beat_be_o    = busy ? sl_be : '0;
  assign beat_last_o  = last;
  assign cfg_err_o    = busy & mode_q.err;
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int LANE_W = 32,
  localparam int LANE_B = LANE_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [LANE_W-1:0] beat_data_o,
  input logic [LANE_B-1:0] beat_be_o,
  input logic              beat_last_o,
  input logic              cfg_err_o
);
  a_r2_accept_then_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> beat_valid_o && !in_ready_o);

  a_r2_release_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_last_o |=> in_ready_o && !beat_valid_o);

  a_r3_continue_until_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o |=> beat_valid_o && !in_ready_o);

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o)
      && $stable(beat_be_o) && $stable(beat_last_o) && $stable(cfg_err_o));

  a_r10_err_with_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> beat_valid_o);
endmodule

bind wdata_beat_splitter wbs_checker #(.LANE_W(LANE_W)) u_wbs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_data_o  (beat_data_o),
  .beat_be_o    (beat_be_o),
  .beat_last_o  (beat_last_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/wdata_beat_splitter_test.sv
module wdata_beat_splitter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] in_data_i = '0;
  logic [7:0]  in_be_i = '0;
  logic        in_big_endian_i = 1'b0;
  logic [0:0]  in_cs_i = '0;
  logic [5:0]  cfg_i = '0;
  logic        beat_valid_o;
  logic        beat_ready_i = 1'b1;
  logic [31:0] beat_data_o;
  logic [3:0]  beat_be_o;
  logic        beat_last_o;
  logic        cfg_err_o;

  wdata_beat_splitter uut (.*);

  initial forever #4 clk_i = ~clk_i;

  int    n_vec = 0;
  int    n_bad = 0;
  int    rdy_mode = 0;
  string cur_tag = "R4";

  logic [31:0] qd[$];
  logic [3:0]  qb[$];
  bit          ql[$];
  bit          qe[$];
  string       qt[$];

  function automatic void chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void push_word(logic [63:0] d, logic [7:0] be, bit big, logic [2:0] code, string tag);
    int w, n;
    bit hi, err, bg;
    w = 32; hi = 0; err = 0; bg = big;
    case (code)
      3'd0: w = 16;
      3'd1: begin w = 16; hi = 1; end
      3'd2: w = 32;
      default: begin bg = 0; err = 1; end
    endcase
    n = 64 / w;
    for (int k = 0; k < n; k++) begin
      int pos;
      logic [63:0] s;
      logic [7:0]  b;
      logic [31:0] dd;
      logic [3:0]  bb;
      pos = bg ? n - 1 - k : k;
      s = d >> (pos * w);
      b = be >> (pos * w / 8);
      if (w == 16) begin
        dd = {16'h0, s[15:0]};
        bb = {2'b0, b[1:0]};
        if (hi) begin dd = dd << 16; bb = bb << 2; end
      end else begin
        dd = s[31:0];
        bb = b[3:0];
      end
      qd.push_back(dd); qb.push_back(bb); ql.push_back(k == n - 1);
      qe.push_back(err); qt.push_back(tag);
    end
  endfunction

  always @(negedge clk_i) begin
    case (rdy_mode)
      0: beat_ready_i <= 1'b1;
      1: beat_ready_i <= 1'($urandom_range(0, 1));
      default: beat_ready_i <= 1'b0;
    endcase
  end

  // reference model, compared 1 ns before each rising edge
  always @(negedge clk_i) begin
    #3;
    if (rst_ni) begin
      bit busy_m;
      busy_m = (qd.size() != 0);
      chk(in_ready_o == !busy_m, "R2", "in_ready", 64'(in_ready_o), 64'(!busy_m));
      chk(beat_valid_o == busy_m, "R2", "beat_valid", 64'(beat_valid_o), 64'(busy_m));
      if (busy_m && beat_valid_o) begin
        chk(beat_data_o == qd[0], qt[0], "beat_data", 64'(beat_data_o), 64'(qd[0]));
        chk(beat_be_o == qb[0], "R7", "beat_be", 64'(beat_be_o), 64'(qb[0]));
        chk(beat_last_o == ql[0], "R3", "beat_last", 64'(beat_last_o), 64'(ql[0]));
        chk(cfg_err_o == qe[0], "R10", "cfg_err", 64'(cfg_err_o), 64'(qe[0]));
      end
      if (in_valid_i && busy_m)
        chk(!in_ready_o, "R11", "ready while busy", 64'(in_ready_o), 64'd0);
      if (busy_m && beat_ready_i) begin
        void'(qd.pop_front()); void'(qb.pop_front()); void'(ql.pop_front());
        void'(qe.pop_front()); void'(qt.pop_front());
      end else if (!busy_m && in_valid_i) begin
        push_word(in_data_i, in_be_i, in_big_endian_i,
                  in_cs_i[0] ? cfg_i[5:3] : cfg_i[2:0], cur_tag);
      end
    end
  end

  task automatic send(logic [63:0] d, logic [7:0] be, bit big, bit cs);
    bit acc;
    acc = 0;
    in_valid_i = 1'b1; in_data_i = d; in_be_i = be;
    in_big_endian_i = big; in_cs_i = cs;
    while (!acc) begin
      #3;
      acc = in_ready_o;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (qd.size() != 0 && g < 500) begin
      @(negedge clk_i);
      g++;
    end
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: idle state under reset
    chk(in_ready_o == 1'b1, "R1", "in_ready", 64'(in_ready_o), 64'd1);
    chk(beat_valid_o == 1'b0, "R1", "beat_valid", 64'(beat_valid_o), 64'd0);
    chk(beat_last_o == 1'b0, "R1", "beat_last", 64'(beat_last_o), 64'd0);
    chk(cfg_err_o == 1'b0, "R1", "cfg_err", 64'(cfg_err_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1 && !beat_valid_o, "R1", "after release", 64'(in_ready_o), 64'd1);

    // R4/R6: little-endian, 16-bit low lane on cs0
    cfg_i = {3'd2, 3'd0}; cur_tag = "R4";
    send(64'h1111_2222_3333_4444, 8'hFF, 0, 0);
    send(64'h0123_4567_89AB_CDEF, 8'hFF, 0, 0);
    wait_idle();
    // R5/R6: big-endian, 16-bit high lane on cs1
    cfg_i = {3'd1, 3'd2}; cur_tag = "R5";
    send(64'hA1A2_B1B2_C1C2_D1D2, 8'hFF, 1, 1);
    cur_tag = "R6";
    send(64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 0, 1);
    wait_idle();
    // R3: 32-bit lane, both orders
    cur_tag = "R3";
    send(64'hFEDC_BA98_7654_3210, 8'hFF, 0, 0);
    send(64'hFEDC_BA98_7654_3210, 8'hFF, 1, 0);
    wait_idle();
    // R7: sparse byte enables in every mode
    cur_tag = "R7";
    cfg_i = {3'd1, 3'd0};
    send(64'h8877_6655_4433_2211, 8'b1001_0110, 1, 0);
    send(64'h8877_6655_4433_2211, 8'b0110_1001, 0, 1);
    cfg_i = {3'd2, 3'd2};
    send(64'h8877_6655_4433_2211, 8'b1100_0001, 1, 1);
    wait_idle();
    // R8: long stall then random stalls
    cur_tag = "R8";
    rdy_mode = 2;
    send(64'h5555_AAAA_3C3C_C3C3, 8'hF0, 1, 0);
    repeat (6) @(negedge clk_i);
    rdy_mode = 1;
    for (int i = 0; i < 40; i++) begin
      logic [2:0] c0, c1;
      c0 = 3'($urandom_range(0, 2));
      c1 = 3'($urandom_range(0, 2));
      cfg_i = {c1, c0};
      send({$urandom, $urandom}, 8'($urandom), 1'($urandom), 1'($urandom));
    end
    wait_idle();
    rdy_mode = 0;
    // R9: code taken from the request's chip select, sampled at acceptance
    cur_tag = "R9";
    cfg_i = {3'd0, 3'd2};
    send(64'h0F0E_0D0C_0B0A_0908, 8'hFF, 0, 1);
    cfg_i = {3'd2, 3'd1};
    wait_idle();
    cfg_i = {3'd0, 3'd2};
    send(64'h0F0E_0D0C_0B0A_0908, 8'h3C, 1, 0);
    cfg_i = {3'd1, 3'd1};
    wait_idle();
    // R10: reserved codes fall back to 32-bit little-endian
    cur_tag = "R10";
    for (int c = 3; c < 8; c++) begin
      cfg_i = {3'd0, 3'(c)};
      send(64'h1357_9BDF_2468_ACE0, 8'hA5, 1, 0);
      cfg_i = {3'(c), 3'd0};
      send(64'h7766_5544_3322_1100, 8'h5A, 1, 1);
    end
    wait_idle();
    // R11: back-to-back requests wait for the previous word
    cur_tag = "R11";
    cfg_i = {3'd2, 3'd0};
    rdy_mode = 1;
    for (int i = 0; i < 8; i++)
      send(64'hC0DE_0000_0000_0000 | 64'(i), 8'hFF, 1'(i), 1'(i >> 1));
    wait_idle();
    rdy_mode = 0;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule